// File: doc/BRIEF.md
# Dual-Buffer DMA Request Controller

This block turns conversion-clock and trigger events into DMA request pulses for a data-acquisition front end that moves samples through two buffers served by two DMA channels, A and B. A single 16-bit supervisory control word chooses which event stream produces requests and whether the two channels are used in alternation. It also enables the error interrupt and carries one-shot initialisation commands. While alternation is on, a terminal-count pulse from the channel currently being served moves later requests to the other channel. The next buffer is then already armed, so the data stream has no gap.

Each completed buffer sets a sticky done flag, which is visible in the control word and on the interrupt line. Software clears it by writing a one to a dedicated bit. The DMA engines are outside the block. They only return a terminal-count pulse per channel.

Top module: `dbuf_dma_req`

## Requirements
- R1: After reset the control word reads 0x0000, no request is asserted, the interrupt is low and all init strobes are low.
- R2: With the source field (bits 11:10) at code 0, no event of any kind produces a request on either channel.
- R3: Source code 1 selects the A/D conversion clock event, code 2 the D/A clock event and code 3 the A/D trigger event. A selected event produces a one-cycle request on the active channel in the cycle after it is sampled.
- R4: With dual mode (bit 12) off, every request goes to channel A. A terminal count on A sets the done flag, and writing the control word with bit 12 clear returns the pointer to A.
- R5: With dual mode on, a terminal count on the active channel sets the done flag and moves the pointer (read back at bit 9, 0 = A, 1 = B) to the other channel, so the next request goes there. A terminal count on the inactive channel is ignored.
- R6: The done flag reads at bit 15. A write with bit 13 set clears it, and a write with bit 13 clear leaves it. When a terminal count coincides with the clearing write, the flag stays set. Bit 13 itself reads 0.
- R7: The interrupt output equals the done flag ORed with (error input AND error enable, bit 14).
- R8: Writing a one to bit 6, bit 5 or bit 0 pulses the A/D-init, D/A-init or board-init output for exactly one cycle. These bits read back 0. A/D-init and D/A-init clear the done flag and return the pointer to A. Board-init clears the whole control word.
- R9: Writing a one to bit 9 returns the pointer to channel A without affecting the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control word and status readback |
| ev_adclk | input | 1 | A/D conversion clock event pulse |
| ev_daclk | input | 1 | D/A clock event pulse |
| ev_adtrig | input | 1 | A/D trigger event pulse |
| tc_a | input | 1 | Terminal count from DMA channel A |
| tc_b | input | 1 | Terminal count from DMA channel B |
| err_in | input | 1 | Converter error condition |
| req_a | output | 1 | DMA request to channel A |
| req_b | output | 1 | DMA request to channel B |
| irq | output | 1 | Interrupt output |
| ad_init | output | 1 | One-cycle A/D initialisation pulse |
| da_init | output | 1 | One-cycle D/A initialisation pulse |
| bd_init | output | 1 | One-cycle board initialisation pulse |

## Verification
Requests, the readback word and the init pulses are all due one clock edge after the stimulus that causes them, because each passes through exactly one register. The interrupt also follows the done flag one edge later, but it follows the error input in the same cycle. The bench applies each stimulus before an edge, samples 2 ns after that edge and clears the pulse inputs only after sampling. Every expected value therefore belongs to exactly one edge. A second sample one cycle after each init write confirms that the pulse has fallen again.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
   localparam int unsigned CSR_W    = 16;
   localparam int unsigned BIT_DONE  = 15;
   localparam int unsigned BIT_ERREN = 14;
   localparam int unsigned BIT_CLR   = 13;
   localparam int unsigned BIT_DUAL  = 12;
   localparam int unsigned BIT_SRC   = 10;
   localparam int unsigned BIT_BUF   = 9;
   localparam int unsigned BIT_AINIT = 6;
   localparam int unsigned BIT_DINIT = 5;
   localparam int unsigned BIT_BINIT = 0;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_ADCLK  = 2'd1,
      SRC_DACLK  = 2'd2,
      SRC_ADTRIG = 2'd3
   } src_e;

   typedef struct packed {
      logic erren;
      logic dual;
      src_e src;
   } cfg_t;
endpackage

// File: rtl/dmarq_csr.sv
module dmarq_csr
   import dmarq_pkg::*;
#(
   parameter int unsigned W = CSR_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output cfg_t         cfg,
   output logic         cmd_clr,
   output logic         cmd_home,
   output logic         cmd_wipe,
   output logic         ad_init,
   output logic         da_init,
   output logic         bd_init
);
   logic wr_binit;

   assign wr_binit = wr & wdata[BIT_BINIT];
   assign cmd_clr  = wr & wdata[BIT_CLR];
   assign cmd_wipe = wr & (wdata[BIT_AINIT] | wdata[BIT_DINIT] | wdata[BIT_BINIT]);
   assign cmd_home = wr & (wdata[BIT_BUF] | wdata[BIT_AINIT] | wdata[BIT_DINIT]
                           | wdata[BIT_BINIT] | ~wdata[BIT_DUAL]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_binit) begin
         cfg <= '0;
      end else if (wr) begin
         cfg.erren <= wdata[BIT_ERREN];
         cfg.dual  <= wdata[BIT_DUAL];
         cfg.src   <= src_e'(wdata[BIT_SRC +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ad_init <= 1'b0;
         da_init <= 1'b0;
         bd_init <= 1'b0;
      end else begin
         ad_init <= wr & wdata[BIT_AINIT];
         da_init <= wr & wdata[BIT_DINIT];
         bd_init <= wr_binit;
      end
   end

   // R8
   ad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ad_init |-> $past(wr && wdata[BIT_AINIT]));
   // R8
   bd_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bd_init |-> (cfg == '0));
endmodule

// File: rtl/dmarq_evsel.sv
module dmarq_evsel
   import dmarq_pkg::*;
#(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned NEV  = (1 << SEL_W) - 1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [NEV-1:0]   ev,
   output logic             hit
);
   logic [NEV-1:0] match;

   for (genvar k = 1; k <= NEV; k++) begin : g_src
      assign match[k-1] = (sel == SEL_W'(k)) & ev[k-1];
   end

   assign hit = |match;
endmodule

// File: rtl/dmarq_pingpong.sv
module dmarq_pingpong (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic tc_a,
   input  logic tc_b,
   input  logic dual,
   input  logic cmd_clr,
   input  logic cmd_home,
   input  logic cmd_wipe,
   output logic req_a,
   output logic req_b,
   output logic ptr_b,
   output logic done
);
   logic tc_act;

   assign tc_act = ptr_b ? tc_b : tc_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_a <= 1'b0;
         req_b <= 1'b0;
      end else begin
         req_a <= hit & ~ptr_b;
         req_b <= hit & ptr_b & dual;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_b <= 1'b0;
      else if (cmd_home)          ptr_b <= 1'b0;
      else if (tc_act && dual)    ptr_b <= ~ptr_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    done <= 1'b0;
      else if (tc_act)               done <= 1'b1;
      else if (cmd_clr || cmd_wipe)  done <= 1'b0;
   end

   // R5
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_a, req_b}));
   // R4
   tc_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_act |=> done);
   // R6
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clr && !tc_act) |=> !done);
   // R4
   single_no_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dual |=> !req_b);
   // R5
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_act && dual && !cmd_home) |=> (ptr_b != $past(ptr_b)));
endmodule

// File: rtl/dbuf_dma_req.sv
module dbuf_dma_req
   import dmarq_pkg::*;
#(
   parameter int unsigned W     = CSR_W,
   parameter int unsigned SEL_W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         csr_wr,
   input  logic [W-1:0] csr_wdata,
   output logic [W-1:0] csr_rdata,
   input  logic         ev_adclk,
   input  logic         ev_daclk,
   input  logic         ev_adtrig,
   input  logic         tc_a,
   input  logic         tc_b,
   input  logic         err_in,
   output logic         req_a,
   output logic         req_b,
   output logic         irq,
   output logic         ad_init,
   output logic         da_init,
   output logic         bd_init
);
   localparam int unsigned NEV = (1 << SEL_W) - 1;

   if (W != 16) begin : g_bad_w
      $error("dbuf_dma_req: control word must be 16 bits");
   end
   if (NEV != 3) begin : g_bad_sel
      $error("dbuf_dma_req: three event sources need a 2-bit selector");
   end

   cfg_t cfg;
   logic cmd_clr, cmd_home, cmd_wipe;
   logic hit, ptr_b, done;

   dmarq_csr #(.W(W)) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (csr_wr),
      .wdata    (csr_wdata),
      .cfg      (cfg),
      .cmd_clr  (cmd_clr),
      .cmd_home (cmd_home),
      .cmd_wipe (cmd_wipe),
      .ad_init  (ad_init),
      .da_init  (da_init),
      .bd_init  (bd_init)
   );

   dmarq_evsel #(.SEL_W(SEL_W)) u_sel (
      .sel (SEL_W'(cfg.src)),
      .ev  ({ev_adtrig, ev_daclk, ev_adclk}),
      .hit (hit)
   );

   dmarq_pingpong u_pp (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .tc_a     (tc_a),
      .tc_b     (tc_b),
      .dual     (cfg.dual),
      .cmd_clr  (cmd_clr),
      .cmd_home (cmd_home),
      .cmd_wipe (cmd_wipe),
      .req_a    (req_a),
      .req_b    (req_b),
      .ptr_b    (ptr_b),
      .done     (done)
   );

   always_comb begin
      csr_rdata = '0;
      csr_rdata[BIT_DONE]     = done;
      csr_rdata[BIT_ERREN]    = cfg.erren;
      csr_rdata[BIT_DUAL]     = cfg.dual;
      csr_rdata[BIT_SRC +: 2] = cfg.src;
      csr_rdata[BIT_BUF]      = ptr_b;
   end

   assign irq = done | (cfg.erren & err_in);

   // R2
   src_none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.src == SRC_NONE) |=> !(req_a || req_b));
   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done || err_in));
endmodule

// File: tb/dbuf_dma_req_bench.sv
`timescale 1ns/1ps
module dbuf_dma_req_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [15:0] csr_wdata = '0;
   logic [15:0] csr_rdata;
   logic        ev_adclk = 1'b0, ev_daclk = 1'b0, ev_adtrig = 1'b0;
   logic        tc_a = 1'b0, tc_b = 1'b0, err_in = 1'b0;
   logic        req_a, req_b, irq, ad_init, da_init, bd_init;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   dbuf_dma_req u_dbuf_dma_req (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .ev_adclk(ev_adclk), .ev_daclk(ev_daclk),
      .ev_adtrig(ev_adtrig), .tc_a(tc_a), .tc_b(tc_b), .err_in(err_in),
      .req_a(req_a), .req_b(req_b), .irq(irq), .ad_init(ad_init),
      .da_init(da_init), .bd_init(bd_init)
   );

   // vector: wr, wdata, {adtrig,daclk,adclk}, tc_a, tc_b, err | exp req_a, req_b, irq, rdata
   localparam int NV = 19;
   localparam logic [41:0] VEC [NV] = '{
      {1'b0, 16'h0000, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
      {1'b1, 16'h0400, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0400}, // R3
      {1'b0, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0400}, // R3
      {1'b0, 16'h0000, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0400}, // R3
      {1'b0, 16'h0000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8400}, // R4
      {1'b0, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h8400}, // R4
      {1'b1, 16'h3400, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1400}, // R6
      {1'b0, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1400}, // R5
      {1'b0, 16'h0000, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1400}, // R5
      {1'b0, 16'h0000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h9600}, // R5
      {1'b0, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h9600}, // R5
      {1'b1, 16'h5600, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hD400}, // R9
      {1'b1, 16'h7400, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5400}, // R6
      {1'b0, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h5400}, // R7
      {1'b1, 16'h1C00, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1C00}, // R7
      {1'b0, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1C00}, // R3
      {1'b1, 16'h3C00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h9E00}, // R6
      {1'b1, 16'h0800, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8800}, // R4
      {1'b0, 16'h0000, 3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h8800}  // R3
   };
   localparam string VTAG [NV] = '{"R2","R3","R3","R3","R4","R4","R6","R5","R5",
                                   "R5","R5","R9","R6","R7","R7","R3","R6","R4","R3"};

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [15:0] wd, input logic [2:0] ev,
                        input logic ta, input logic tb, input logic er);
      csr_wr = wr; csr_wdata = wd;
      {ev_adtrig, ev_daclk, ev_adclk} = ev;
      tc_a = ta; tc_b = tb; err_in = er;
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      csr_wr = 1'b0; csr_wdata = '0;
      {ev_adtrig, ev_daclk, ev_adclk} = '0;
      tc_a = 1'b0; tc_b = 1'b0; err_in = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;
      // R1 reset state
      check("R1", "rdata", 32'(csr_rdata), 32'h0);
      check("R1", "req", 32'({req_a, req_b}), 32'h0);
      check("R1", "irq", 32'(irq), 32'h0);
      check("R1", "strobes", 32'({ad_init, da_init, bd_init}), 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][41], VEC[i][40:25], VEC[i][24:22], VEC[i][21], VEC[i][20], VEC[i][19]);
         check(VTAG[i], $sformatf("vec%0d req_a", i), 32'(req_a), 32'(VEC[i][18]));
         check(VTAG[i], $sformatf("vec%0d req_b", i), 32'(req_b), 32'(VEC[i][17]));
         check(VTAG[i], $sformatf("vec%0d irq", i), 32'(irq), 32'(VEC[i][16]));
         check(VTAG[i], $sformatf("vec%0d rdata", i), 32'(csr_rdata), 32'(VEC[i][15:0]));
         idle();
      end

      // R8 A/D init: done set (0x8800) -> cleared, pulse one cycle
      drive(1'b1, 16'h1440, 3'b000, 1'b0, 1'b0, 1'b0);
      check("R8", "ad_init high", 32'(ad_init), 32'h1);
      check("R8", "rdata after ad init", 32'(csr_rdata), 32'h1400);
      check("R8", "irq after ad init", 32'(irq), 32'h0);
      idle();
      @(posedge clk); #2;
      check("R8", "ad_init low", 32'(ad_init), 32'h0);

      // move to B with done, then D/A init returns to A and clears done
      drive(1'b0, 16'h0000, 3'b000, 1'b1, 1'b0, 1'b0);
      check("R5", "rdata after tc", 32'(csr_rdata), 32'h9600);
      idle();
      drive(1'b1, 16'h1420, 3'b000, 1'b0, 1'b0, 1'b0);
      check("R8", "da_init high", 32'(da_init), 32'h1);
      check("R8", "rdata after da init", 32'(csr_rdata), 32'h1400);
      idle();
      @(posedge clk); #2;
      check("R8", "da_init low", 32'(da_init), 32'h0);

      // R8 board init wipes the word
      drive(1'b1, 16'h5401, 3'b000, 1'b0, 1'b0, 1'b0);
      check("R8", "bd_init high", 32'(bd_init), 32'h1);
      check("R8", "rdata after board init", 32'(csr_rdata), 32'h0);
      idle();
      @(posedge clk); #2;
      check("R8", "bd_init low", 32'(bd_init), 32'h0);

      // R2 again after board init: source none, events ignored
      drive(1'b0, 16'h0000, 3'b111, 1'b0, 1'b0, 1'b0);
      check("R2", "req after wipe", 32'({req_a, req_b}), 32'h0);
      idle();

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule